// File: doc/BRIEF.md
# Dual-Mode Cross-Clock Word Transfer Channel

This block carries a stream of 16-bit words from a producing unit to a consuming unit whose clocks are not related in any way. It is built either as an unbuffered meeting point or as a buffered queue. A build-time parameter makes the choice, and only the chosen path becomes logic. In meeting-point mode, a word moves only when the producer offers it and the consumer asks for it. Each side waits for the other through a four-phase request/acknowledge exchange, and the word crosses on a held data bus with no storage. In queue mode, the producer never waits. Its words go into a dual-clock queue with Gray-coded pointers, and a write that finds the queue full is discarded and reported.

On the consumer side, a read is either waiting or polling. A waiting read stays silent until a word is there. A polling read that finds nothing returns a "nothing there" pulse at once. Each side counts the words that actually moved. When an array of a configured length is complete, that side raises a one-cycle done pulse aligned with the last word.

Top module: `xfer_channel`

## Requirements
- R1: After either reset, sndReady, sndOverflow, sndDone, rcvValid, rcvNoData and rcvDone are all 0.
- R2: In meeting-point mode (MODE = MODE_RENDEZVOUS), an offered word is neither delivered on rcvValid nor acknowledged on sndReady while rcvReq is held low.
- R3: In meeting-point mode, every word offered is delivered exactly once, in order and unchanged. sndReady pulses once per word, after the consumer has taken it.
- R4: In meeting-point mode, the producer holds sndValid and sndData until sndReady. The word is captured when the channel is idle and stays on the crossing bus until acknowledged.
- R5: In queue mode (MODE = MODE_FIFO), sndValid is a one-cycle write strobe. A write to a queue that is not full gives sndReady = 1 on the next sndClk cycle. Accepted words leave on rcvValid/rcvData in write order.
- R6: In queue mode, a write while the queue holds FIFO_DEPTH words is dropped and gives sndOverflow = 1 (and sndReady = 0) on the next sndClk cycle. A dropped word is never delivered. With no reads, exactly FIFO_DEPTH back-to-back writes are accepted.
- R7: A waiting read (rcvReq = 1, rcvBlocking = 1) with no word available produces neither rcvValid nor rcvNoData.
- R8: A polling read (rcvReq = 1, rcvBlocking = 0) with no word available gives rcvNoData = 1 on the next rcvClk cycle, once per cycle the request is held. This holds in both modes.
- R9: sndDone is 1 in the cycle of the ARRAY_WORDS-th sndReady of each array, and rcvDone in the cycle of the ARRAY_WORDS-th rcvValid. Both are 0 otherwise, and counting restarts after each array.
- R10: Dropped writes are not counted toward the array length on the producer side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sndClk | input | 1 | Producer clock |
| sndRstN | input | 1 | Producer reset, active low, asynchronous |
| sndValid | input | 1 | Offer (meeting point) or write strobe (queue) |
| sndData | input | WORD_W | Word offered by the producer |
| sndReady | output | 1 | One-cycle pulse: word taken |
| sndOverflow | output | 1 | One-cycle pulse: write dropped, queue full |
| sndDone | output | 1 | One-cycle pulse with the last word of an array |
| rcvClk | input | 1 | Consumer clock |
| rcvRstN | input | 1 | Consumer reset, active low, asynchronous |
| rcvReq | input | 1 | Consumer asks for a word |
| rcvBlocking | input | 1 | 1 = waiting read, 0 = polling read |
| rcvValid | output | 1 | One-cycle pulse: rcvData holds a new word |
| rcvData | output | WORD_W | Delivered word |
| rcvNoData | output | 1 | One-cycle pulse: polling read found nothing |
| rcvDone | output | 1 | One-cycle pulse with the last word of an array |

## Verification
The assertions assume a meeting-point producer that keeps sndValid and sndData steady from its offer until sndReady, and a queue depth that is a power of two. The bench's sender task holds the offer until it sees the acknowledge. In queue mode, it drives each write strobe for a single cycle. Random gaps of at least one idle producer cycle keep the stream slower than the consumer, so only the directed fill case overflows.

// File: rtl/xfer_chan_pkg.sv
package xfer_chan_pkg;

  typedef enum logic {
    MODE_RENDEZVOUS = 1'b0,
    MODE_FIFO       = 1'b1
  } chanMode_e;

  // per-side word-moved events, each in its own clock domain
  typedef struct packed {
    logic sndBeat;
    logic rcvBeat;
  } beatStrobes_t;

endpackage

// File: rtl/xfer_rdv_path.sv
module xfer_rdv_path
  import xfer_chan_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              sndClk,
  input  logic              sndRstN,
  input  logic              sndValid,
  input  logic [WORD_W-1:0] sndData,
  output logic              sndReady,
  input  logic              rcvClk,
  input  logic              rcvRstN,
  input  logic              rcvReq,
  input  logic              rcvBlocking,
  output logic              rcvValid,
  output logic [WORD_W-1:0] rcvData,
  output logic              rcvNoData,
  output beatStrobes_t      strobes
);

  logic              reqOut, ackOut;
  logic [1:0]        reqSyncQ, ackSyncQ;
  logic              reqSeen, ackSeen;
  logic [WORD_W-1:0] holdData;
  logic              sndStart, sndFinish, rcvTake, rcvMiss;

  assign reqSeen = reqSyncQ[1];
  assign ackSeen = ackSyncQ[1];

  // producer side: raise request only after previous ack has fully returned low
  assign sndStart  = sndValid && !reqOut && !ackSeen;
  assign sndFinish = reqOut && ackSeen;

  always_ff @(posedge sndClk or negedge sndRstN) begin
    if (!sndRstN) begin
      reqOut   <= 1'b0;
      holdData <= '0;
      sndReady <= 1'b0;
      ackSyncQ <= '0;
    end else begin
      ackSyncQ <= {ackSyncQ[0], ackOut};
      sndReady <= sndFinish;
      if (sndStart) begin
        reqOut   <= 1'b1;
        holdData <= sndData;
      end else if (sndFinish) begin
        reqOut <= 1'b0;
      end
    end
  end

  // consumer side: take the word once per request phase
  assign rcvTake = reqSeen && !ackOut && rcvReq;
  assign rcvMiss = rcvReq && !rcvBlocking && !(reqSeen && !ackOut);

  always_ff @(posedge rcvClk or negedge rcvRstN) begin
    if (!rcvRstN) begin
      reqSyncQ  <= '0;
      ackOut    <= 1'b0;
      rcvValid  <= 1'b0;
      rcvNoData <= 1'b0;
      rcvData   <= '0;
    end else begin
      reqSyncQ  <= {reqSyncQ[0], reqOut};
      rcvValid  <= rcvTake;
      rcvNoData <= rcvMiss;
      if (rcvTake) begin
        ackOut  <= 1'b1;
        rcvData <= holdData;
      end else if (!reqSeen && ackOut) begin
        ackOut <= 1'b0;
      end
    end
  end

  assign strobes.sndBeat = sndFinish;
  assign strobes.rcvBeat = rcvTake;

  // R4
  hold_stable_chk: assert property (@(posedge sndClk) disable iff (!sndRstN)
    (reqOut && !ackSeen) |=> $stable(holdData));

  // R3
  req_rise_chk: assert property (@(posedge sndClk) disable iff (!sndRstN)
    $rose(reqOut) |-> !ackSeen);

  // R3
  ack_hold_chk: assert property (@(posedge rcvClk) disable iff (!rcvRstN)
    (ackOut && reqSeen) |=> ackOut);

  // R2
  valid_needs_req_chk: assert property (@(posedge rcvClk) disable iff (!rcvRstN)
    rcvValid |-> $past(rcvReq));

endmodule

// File: rtl/xfer_fifo_path.sv
module xfer_fifo_path
  import xfer_chan_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              sndClk,
  input  logic              sndRstN,
  input  logic              sndValid,
  input  logic [WORD_W-1:0] sndData,
  output logic              sndReady,
  output logic              sndOverflow,
  input  logic              rcvClk,
  input  logic              rcvRstN,
  input  logic              rcvReq,
  input  logic              rcvBlocking,
  output logic              rcvValid,
  output logic [WORD_W-1:0] rcvData,
  output logic              rcvNoData,
  output beatStrobes_t      strobes
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WORD_W-1:0] store [DEPTH];
  logic [PW-1:0]     wBin, wGray, rBin, rGray;
  logic [PW-1:0]     rGrayQ1, rGrayQ2, wGrayQ1, wGrayQ2;
  logic [PW-1:0]     rBinSeen, wBinSeen, wBinNext, rBinNext;
  logic              isFull, isEmpty;
  logic              sndWrite, sndDrop, rcvTake, rcvMiss;

  assign rBinSeen = gray2bin(rGrayQ2);
  assign wBinSeen = gray2bin(wGrayQ2);
  assign wBinNext = wBin + 1'b1;
  assign rBinNext = rBin + 1'b1;

  // flags use the stale view of the far pointer: never optimistic
  assign isFull  = (wBin - rBinSeen) == PW'(DEPTH);
  assign isEmpty = (rBin == wBinSeen);

  assign sndWrite = sndValid && !isFull;
  assign sndDrop  = sndValid && isFull;

  always_ff @(posedge sndClk) begin
    if (sndWrite) store[wBin[AW-1:0]] <= sndData;
  end

  always_ff @(posedge sndClk or negedge sndRstN) begin
    if (!sndRstN) begin
      wBin        <= '0;
      wGray       <= '0;
      rGrayQ1     <= '0;
      rGrayQ2     <= '0;
      sndReady    <= 1'b0;
      sndOverflow <= 1'b0;
    end else begin
      rGrayQ1     <= rGray;
      rGrayQ2     <= rGrayQ1;
      sndReady    <= sndWrite;
      sndOverflow <= sndDrop;
      if (sndWrite) begin
        wBin  <= wBinNext;
        wGray <= bin2gray(wBinNext);
      end
    end
  end

  assign rcvTake = rcvReq && !isEmpty;
  assign rcvMiss = rcvReq && isEmpty && !rcvBlocking;

  always_ff @(posedge rcvClk or negedge rcvRstN) begin
    if (!rcvRstN) begin
      rBin      <= '0;
      rGray     <= '0;
      wGrayQ1   <= '0;
      wGrayQ2   <= '0;
      rcvValid  <= 1'b0;
      rcvNoData <= 1'b0;
      rcvData   <= '0;
    end else begin
      wGrayQ1   <= wGray;
      wGrayQ2   <= wGrayQ1;
      rcvValid  <= rcvTake;
      rcvNoData <= rcvMiss;
      if (rcvTake) begin
        rcvData <= store[rBin[AW-1:0]];
        rBin    <= rBinNext;
        rGray   <= bin2gray(rBinNext);
      end
    end
  end

  assign strobes.sndBeat = sndWrite;
  assign strobes.rcvBeat = rcvTake;

  // R6
  occupancy_chk: assert property (@(posedge sndClk) disable iff (!sndRstN)
    (wBin - rBinSeen) <= PW'(DEPTH));

  // R6
  drop_excl_chk: assert property (@(posedge sndClk) disable iff (!sndRstN)
    sndOverflow |-> !sndReady);

  // R8
  nodata_poll_chk: assert property (@(posedge rcvClk) disable iff (!rcvRstN)
    rcvNoData |-> $past(rcvReq && !rcvBlocking));

  // R7
  valid_nodata_excl_chk: assert property (@(posedge rcvClk) disable iff (!rcvRstN)
    !(rcvValid && rcvNoData));

endmodule

// File: rtl/xfer_word_counter.sv
module xfer_word_counter #(
  parameter int ARRAY_WORDS = 128
) (
  input  logic clk,
  input  logic rstN,
  input  logic beat,
  output logic done
);

  localparam int CW = (ARRAY_WORDS > 1) ? $clog2(ARRAY_WORDS) : 1;
  localparam logic [CW-1:0] LAST = CW'(ARRAY_WORDS - 1);

  logic [CW-1:0] wordCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= beat && (wordCnt == LAST);
      if (beat) wordCnt <= (wordCnt == LAST) ? '0 : wordCnt + 1'b1;
    end
  end

  // R9
  done_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (wordCnt == '0));

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordCnt <= LAST);

endmodule

// File: rtl/xfer_channel.sv
module xfer_channel
  import xfer_chan_pkg::*;
#(
  parameter int        WORD_W      = 16,
  parameter int        ARRAY_WORDS = 128,
  parameter int        FIFO_DEPTH  = 16,
  parameter chanMode_e MODE        = MODE_FIFO
) (
  input  logic              sndClk,
  input  logic              sndRstN,
  input  logic              sndValid,
  input  logic [WORD_W-1:0] sndData,
  output logic              sndReady,
  output logic              sndOverflow,
  output logic              sndDone,
  input  logic              rcvClk,
  input  logic              rcvRstN,
  input  logic              rcvReq,
  input  logic              rcvBlocking,
  output logic              rcvValid,
  output logic [WORD_W-1:0] rcvData,
  output logic              rcvNoData,
  output logic              rcvDone
);

  beatStrobes_t strobes;

  generate
    if (MODE == MODE_FIFO) begin : g_fifo
      xfer_fifo_path #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) path_i (
        .sndClk(sndClk), .sndRstN(sndRstN), .sndValid(sndValid), .sndData(sndData),
        .sndReady(sndReady), .sndOverflow(sndOverflow),
        .rcvClk(rcvClk), .rcvRstN(rcvRstN), .rcvReq(rcvReq), .rcvBlocking(rcvBlocking),
        .rcvValid(rcvValid), .rcvData(rcvData), .rcvNoData(rcvNoData),
        .strobes(strobes)
      );
    end else begin : g_rdv
      xfer_rdv_path #(.WORD_W(WORD_W)) path_i (
        .sndClk(sndClk), .sndRstN(sndRstN), .sndValid(sndValid), .sndData(sndData),
        .sndReady(sndReady),
        .rcvClk(rcvClk), .rcvRstN(rcvRstN), .rcvReq(rcvReq), .rcvBlocking(rcvBlocking),
        .rcvValid(rcvValid), .rcvData(rcvData), .rcvNoData(rcvNoData),
        .strobes(strobes)
      );
      assign sndOverflow = 1'b0;
    end
  endgenerate

  xfer_word_counter #(.ARRAY_WORDS(ARRAY_WORDS)) sndCnt_i (
    .clk(sndClk), .rstN(sndRstN), .beat(strobes.sndBeat), .done(sndDone)
  );

  xfer_word_counter #(.ARRAY_WORDS(ARRAY_WORDS)) rcvCnt_i (
    .clk(rcvClk), .rstN(rcvRstN), .beat(strobes.rcvBeat), .done(rcvDone)
  );

endmodule

// File: tb/xfer_channel_tb_top.sv
`timescale 1ns/1ps
module xfer_channel_tb_top;
  import xfer_chan_pkg::*;

  localparam int WW = 16;
  localparam int NW = 16;
  localparam int FD = 8;

  logic sndClk = 1'b0, rcvClk = 1'b0, rstN = 1'b0;
  always #5 sndClk = ~sndClk;
  always #7 rcvClk = ~rcvClk;

  // queue-mode channel
  logic fSndValid = 0, fRcvReq = 0, fRcvBlk = 1;
  logic [WW-1:0] fSndData = '0, fRcvData;
  logic fSndReady, fSndOvf, fSndDone, fRcvValid, fRcvNoData, fRcvDone;
  // meeting-point channel
  logic rSndValid = 0, rRcvReq = 0, rRcvBlk = 1;
  logic [WW-1:0] rSndData = '0, rRcvData;
  logic rSndReady, rSndOvf, rSndDone, rRcvValid, rRcvNoData, rRcvDone;

  xfer_channel #(.WORD_W(WW), .ARRAY_WORDS(NW), .FIFO_DEPTH(FD), .MODE(MODE_FIFO)) dut_i (
    .sndClk(sndClk), .sndRstN(rstN), .sndValid(fSndValid), .sndData(fSndData),
    .sndReady(fSndReady), .sndOverflow(fSndOvf), .sndDone(fSndDone),
    .rcvClk(rcvClk), .rcvRstN(rstN), .rcvReq(fRcvReq), .rcvBlocking(fRcvBlk),
    .rcvValid(fRcvValid), .rcvData(fRcvData), .rcvNoData(fRcvNoData), .rcvDone(fRcvDone));

  xfer_channel #(.WORD_W(WW), .ARRAY_WORDS(NW), .FIFO_DEPTH(FD), .MODE(MODE_RENDEZVOUS)) dut_rdv_i (
    .sndClk(sndClk), .sndRstN(rstN), .sndValid(rSndValid), .sndData(rSndData),
    .sndReady(rSndReady), .sndOverflow(rSndOvf), .sndDone(rSndDone),
    .rcvClk(rcvClk), .rcvRstN(rstN), .rcvReq(rRcvReq), .rcvBlocking(rRcvBlk),
    .rcvValid(rRcvValid), .rcvData(rRcvData), .rcvNoData(rRcvNoData), .rcvDone(rRcvDone));

  int nChecks = 0, nFail = 0;
  logic [WW-1:0] fExp[$], fGot[$], rExp[$], rGot[$];
  int fNoData = 0, rNoData = 0, fSndAcc = 0, fSndDones = 0, rSndAcc = 0;
  int fRcvCnt = 0, rRcvCnt = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit isLastOfArray(input int count);
    return (count % NW) == 0;
  endfunction

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  // consumer-side monitors, R9 alignment of rcvDone
  always @(negedge rcvClk) if (rstN) begin
    if (fRcvValid) begin
      fGot.push_back(fRcvData); fRcvCnt++;
      check(fRcvDone == isLastOfArray(fRcvCnt), "R9 fifo rcvDone", fRcvDone, isLastOfArray(fRcvCnt));
    end else if (fRcvDone) check(0, "R9 fifo rcvDone stray", 1, 0);
    if (fRcvNoData) fNoData++;
    if (rRcvValid) begin
      rGot.push_back(rRcvData); rRcvCnt++;
      check(rRcvDone == isLastOfArray(rRcvCnt), "R9 rdv rcvDone", rRcvDone, isLastOfArray(rRcvCnt));
    end else if (rRcvDone) check(0, "R9 rdv rcvDone stray", 1, 0);
    if (rRcvNoData) rNoData++;
  end

  // queue-mode write: one-cycle strobe, result sampled at the following negedge
  task automatic fWrite(input logic [WW-1:0] d, output bit acc, output bit ovf);
    fSndValid = 1'b1; fSndData = d;
    @(negedge sndClk);
    fSndValid = 1'b0;
    acc = fSndReady; ovf = fSndOvf;
    if (acc) begin
      fSndAcc++; fExp.push_back(d);
      check(fSndDone == isLastOfArray(fSndAcc), "R9 R10 fifo sndDone", fSndDone, isLastOfArray(fSndAcc));
      if (fSndDone) fSndDones++;
    end else check(!fSndDone, "R10 sndDone on drop", fSndDone, 0);
  endtask

  // meeting-point send: hold offer until acknowledged
  task automatic rSend(input logic [WW-1:0] d);
    int guard = 0;
    @(negedge sndClk);
    rSndValid = 1'b1; rSndData = d;
    do begin @(negedge sndClk); guard++; end while (!rSndReady && guard < 300);
    rSndValid = 1'b0;
    check(rSndReady, "R3 sndReady seen", rSndReady, 1);
    rSndAcc++; rExp.push_back(d);
    check(rSndDone == isLastOfArray(rSndAcc), "R9 rdv sndDone", rSndDone, isLastOfArray(rSndAcc));
  endtask

  initial begin
    #2_000_000;
    check(0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    bit acc, ovf;
    int seedInit;
    int startNd;
    bit sawReady;
    seedInit = $urandom(32'h5EED);
    repeat (5) @(negedge sndClk);
    rstN = 1'b1;
    @(negedge sndClk);
    // R1
    check({fSndReady, fSndOvf, fSndDone, fRcvValid, fRcvNoData, fRcvDone} == 6'b0, "R1 fifo reset", 1, 0);
    check({rSndReady, rSndOvf, rSndDone, rRcvValid, rRcvNoData, rRcvDone} == 6'b0, "R1 rdv reset", 1, 0);

    // R7 waiting read on empty queue
    @(negedge rcvClk); fRcvReq = 1; fRcvBlk = 1;
    repeat (20) @(negedge rcvClk);
    fRcvReq = 0;
    check(fGot.size() == 0 && fNoData == 0, "R7 blocking empty", fGot.size() + fNoData, 0);

    // R6 fill with no reader: first FD accepted, rest dropped
    @(negedge sndClk);
    for (int i = 0; i < FD + 3; i++) begin
      fWrite(WW'(16'hA000 + i), acc, ovf);
      if (i < FD) check(acc && !ovf, "R5 accept while room", {acc, ovf}, 2);
      else        check(!acc && ovf, "R6 overflow drop", {acc, ovf}, 1);
    end
    check(fSndAcc == FD, "R6 accepted count", fSndAcc, FD);

    // R5 drain in order, dropped words absent
    @(negedge rcvClk); fRcvReq = 1; fRcvBlk = 1;
    repeat (40) @(negedge rcvClk);
    check(fGot.size() == FD, "R6 delivered count", fGot.size(), FD);

    // R8 polling read on empty queue
    startNd = fNoData;
    fRcvBlk = 0;
    repeat (3) @(negedge rcvClk);
    fRcvBlk = 1;
    @(negedge rcvClk);
    check(fNoData - startNd == 3, "R8 fifo nodata pulses", fNoData - startNd, 3);

    // R5 random stream with gaps, reader always on
    @(negedge sndClk);
    for (int i = 0; i < 40; i++) begin
      fWrite(WW'($urandom), acc, ovf);
      check(acc && !ovf, "R5 stream accept", {acc, ovf}, 2);
      repeat (1 + ($urandom % 3)) @(negedge sndClk);
    end
    repeat (100) @(negedge rcvClk);
    check(fGot.size() == fExp.size(), "R5 fifo total", fGot.size(), fExp.size());
    for (int i = 0; i < fExp.size() && i < fGot.size(); i++)
      check(fGot[i] == fExp[i], "R5 fifo order/data", fGot[i], fExp[i]);
    check(fSndDones == 3, "R9 fifo sndDone count", fSndDones, 3);
    check(fRcvCnt == 3 * NW, "R9 fifo rcv count", fRcvCnt, 3 * NW);

    // R8 meeting point polling with nothing offered
    @(negedge rcvClk); rRcvReq = 1; rRcvBlk = 0;
    @(negedge rcvClk);
    check(rRcvNoData == 1, "R8 rdv nodata", rRcvNoData, 1);
    rRcvReq = 0; rRcvBlk = 1;

    // R2 offer with consumer absent: nothing moves
    @(negedge sndClk);
    rSndValid = 1; rSndData = 16'h5A5A;
    sawReady = 0;
    repeat (30) begin @(negedge sndClk); if (rSndReady) sawReady = 1; end
    check(!sawReady, "R2 no ack without consumer", sawReady, 0);
    check(rGot.size() == 0, "R2 no delivery without consumer", rGot.size(), 0);
    @(negedge rcvClk); rRcvReq = 1;
    begin
      int guard = 0;
      do begin @(negedge sndClk); guard++; end while (!rSndReady && guard < 300);
    end
    rSndValid = 0;
    check(rSndReady, "R4 held offer acknowledged", rSndReady, 1);
    rSndAcc++; rExp.push_back(16'h5A5A);
    repeat (10) @(negedge rcvClk);
    check(rGot.size() == 1 && rGot[0] == 16'h5A5A, "R4 held word delivered", rGot.size(), 1);

    // R3 random words through the handshake
    for (int i = 0; i < 2 * NW - 1; i++) rSend(WW'($urandom));
    repeat (20) @(negedge rcvClk);
    check(rGot.size() == rExp.size(), "R3 rdv total", rGot.size(), rExp.size());
    for (int i = 0; i < rExp.size() && i < rGot.size(); i++)
      check(rGot[i] == rExp[i], "R3 rdv order/data", rGot[i], rExp[i]);
    check(rRcvCnt == 2 * NW, "R9 rdv rcv count", rRcvCnt, 2 * NW);

    finishRun();
  end

endmodule